// File: doc/BRIEF.md
# Eight-Point Fixed-Point Forward DCT Pipeline

This block turns a vector of eight signed 16-bit samples into eight signed 16-bit DCT-II coefficients. It is a one-dimensional stage. A two-dimensional transform is built around it by running rows, then columns, with the transposition and any pre-scaling done outside. The arithmetic is a fixed integer factorisation with 14 fraction bits. Each product is rounded back to 16 bits at defined points, so the results match a bit-exact integer model. They do not match an ideal real-valued DCT.

The datapath has three register stages:
- **Stage 1** registers the mirrored sums and differences.
- **Stage 2** registers the four even coefficients and the four odd-half intermediates.
- **Stage 3** registers the finished vector.

Both edges of the block use valid/ready.
- A vector is taken on a rising edge where `in_valid` and `in_ready` are both high.
- A result leaves on a rising edge where `out_valid` and `out_ready` are both high.
- While `out_valid` is high and `out_ready` is low, the whole pipe freezes and `in_ready` drops. Nothing is dropped or reordered.
- Bubbles in the pipe are carried along like data.

Top module: `fdct8_pipe`

## Requirements
- R1: During and right after reset, `out_valid` is 0 and `in_ready` is 1, whatever `out_ready` is.
- R2: With `out_ready` held high, a vector accepted at rising edge n is presented on `out_data` with `out_valid` high right after edge n+2, that is, three clock edges counting the accepting edge.
- R3: Back-pressure works as follows. While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0, and at the next edge `out_valid` stays 1 with `out_data` unchanged. In every other cycle `in_ready` is 1.
- R4: Stage one forms, in 16-bit two's complement with wrap-around, the sums s0=x0+x7, s1=x1+x6, s2=x2+x5, s3=x3+x4 and the differences s4=x3-x4, s5=x2-x5, s6=x1-x6, s7=x0-x7.
- R5: The even half sets e0=s0+s3 and e1=s1+s2 (both wrapped to 16 bits). Y0=rnd((e0+e1)*11585) and Y4=rnd((e0-e1)*11585), where the sum and difference are taken at full 32-bit width.
- R6: The even half also sets e2=s1-s2 and e3=s0-s3 (both wrapped to 16 bits). Y2=rnd(e2*6270+e3*15137) and Y6=rnd(e3*6270-e2*15137), both accumulated at 32 bits.
- R7: The odd half rounds two intermediates to 16 bits: p=rnd(w(s6-s5)*11585) and q=rnd(w(s6+s5)*11585), where w means wrap to 16 bits. It then forms the wrapped values o0=s4+p, o1=s4-p, o2=s7-q and o3=s7+q.
- R8: The odd coefficients are Y1=rnd(o3*16069+o0*3196), Y5=rnd(o1*13623+o2*9102), Y3=rnd(o2*13623-o1*9102) and Y7=rnd(o3*3196-o0*16069).
- R9: rnd(v) adds 8192 to the 32-bit value v, shifts it right arithmetically by 14, and keeps the low 16 bits.
- R10: Sample i enters on `in_data[16*i+15:16*i]` and coefficient k leaves on `out_data[16*k+15:16*k]`, both as two's complement.
- R11: Every accepted vector yields exactly one result, and results leave in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears all valid flags |
| in_valid | input | 1 | Sample vector on `in_data` is offered |
| in_ready | output | 1 | Pipe can take a vector this cycle |
| in_data | input | 128 | Eight signed 16-bit samples, sample i in bits 16i+15..16i |
| out_valid | output | 1 | Coefficient vector on `out_data` is valid |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 128 | Eight signed 16-bit coefficients, coefficient k in bits 16k+15..16k |

## Verification
The bench uses mirrored samples at full scale so that the 16-bit stage-one sums wrap. A design that saturated, or carried a 17th bit, would give different even and odd coefficients. Small inputs that land the rounded product on a half step catch a missing or misplaced 8192 bias. Inputs that move the pre-rounded odd intermediates catch a design that skips rounding p and q, which would shift Y1, Y3, Y5 and Y7 by one or more. Impulses at each sample position, together with random back-pressure, expose swapped lanes, a lost or duplicated vector under a stall, and output data that changes while it is not taken.

// File: rtl/fdct8_pkg.sv
package fdct8_pkg;

  parameter int unsigned SAMPLE_W = 16;
  parameter int unsigned N_PTS    = 8;
  parameter int unsigned FRAC_W   = 14;
  parameter int unsigned PROD_W   = 32;

  localparam int unsigned HALF_PTS = N_PTS / 2;
  localparam int unsigned VEC_W    = N_PTS * SAMPLE_W;

  typedef logic signed [SAMPLE_W-1:0] smp_t;
  typedef logic signed [PROD_W-1:0]   prod_t;
  typedef logic [N_PTS-1:0][SAMPLE_W-1:0] vec_t;

  localparam prod_t ROUND_BIAS = prod_t'(1) <<< (FRAC_W - 1);

  // cosine constants scaled by 2^FRAC_W, index = multiple of pi/64
  localparam prod_t K4  = prod_t'(16069);
  localparam prod_t K8  = prod_t'(15137);
  localparam prod_t K12 = prod_t'(13623);
  localparam prod_t K16 = prod_t'(11585);
  localparam prod_t K20 = prod_t'(9102);
  localparam prod_t K24 = prod_t'(6270);
  localparam prod_t K28 = prod_t'(3196);

  function automatic prod_t widen(smp_t a);
    return prod_t'(a);
  endfunction

  // a*ca + b*cb, or a*ca - b*cb when sub is set
  function automatic prod_t mac2(smp_t a, prod_t ca, smp_t b, prod_t cb, logic sub);
    prod_t pa;
    prod_t pb;
    pa = widen(a) * ca;
    pb = widen(b) * cb;
    return sub ? (pa - pb) : (pa + pb);
  endfunction

  function automatic smp_t round_narrow(prod_t v);
    prod_t t;
    t = (v + ROUND_BIAS) >>> FRAC_W;
    return t[SAMPLE_W-1:0];
  endfunction

endpackage

// File: rtl/fdct8_split.sv
module fdct8_split
  import fdct8_pkg::*;
(
  input  vec_t x_i,
  output vec_t s_o
);

  for (genvar i = 0; i < HALF_PTS; i++) begin : g_pair
    localparam int unsigned M = N_PTS - 1 - i;
    smp_t a;
    smp_t b;
    assign a      = $signed(x_i[i]);
    assign b      = $signed(x_i[M]);
    assign s_o[i] = a + b;
    assign s_o[M] = a - b;

    always_comb begin
      AST_SPLIT_PAIR: assert (SAMPLE_W'(s_o[i] + s_o[M]) == SAMPLE_W'({x_i[i], 1'b0})); // R4
    end
  end

endmodule

// File: rtl/fdct8_even.sv
module fdct8_even
  import fdct8_pkg::*;
(
  input  smp_t s0_i,
  input  smp_t s1_i,
  input  smp_t s2_i,
  input  smp_t s3_i,
  output smp_t y0_o,
  output smp_t y2_o,
  output smp_t y4_o,
  output smp_t y6_o
);

  smp_t  e0, e1, e2, e3;
  prod_t acc0, acc2, acc4, acc6;

  always_comb begin
    e0   = s0_i + s3_i;
    e1   = s1_i + s2_i;
    e2   = s1_i - s2_i;
    e3   = s0_i - s3_i;
    acc0 = (widen(e0) + widen(e1)) * K16;
    acc4 = (widen(e0) - widen(e1)) * K16;
    acc2 = mac2(e2, K24, e3, K8, 1'b0);
    acc6 = mac2(e3, K24, e2, K8, 1'b1);
    y0_o = round_narrow(acc0);
    y4_o = round_narrow(acc4);
    y2_o = round_narrow(acc2);
    y6_o = round_narrow(acc6);
  end

endmodule

// File: rtl/fdct8_odd_pre.sv
module fdct8_odd_pre
  import fdct8_pkg::*;
(
  input  smp_t s4_i,
  input  smp_t s5_i,
  input  smp_t s6_i,
  input  smp_t s7_i,
  output smp_t o0_o,
  output smp_t o1_o,
  output smp_t o2_o,
  output smp_t o3_o
);

  smp_t dif, sum, p, q;

  always_comb begin
    dif  = s6_i - s5_i;
    sum  = s6_i + s5_i;
    p    = round_narrow(widen(dif) * K16);
    q    = round_narrow(widen(sum) * K16);
    o0_o = s4_i + p;
    o1_o = s4_i - p;
    o2_o = s7_i - q;
    o3_o = s7_i + q;
  end

  always_comb begin
    AST_ODD_MIRROR_LO: assert (SAMPLE_W'(o0_o + o1_o) == SAMPLE_W'({s4_i, 1'b0})); // R7
    AST_ODD_MIRROR_HI: assert (SAMPLE_W'(o2_o + o3_o) == SAMPLE_W'({s7_i, 1'b0})); // R7
  end

endmodule

// File: rtl/fdct8_odd_post.sv
module fdct8_odd_post
  import fdct8_pkg::*;
(
  input  smp_t o0_i,
  input  smp_t o1_i,
  input  smp_t o2_i,
  input  smp_t o3_i,
  output smp_t y1_o,
  output smp_t y3_o,
  output smp_t y5_o,
  output smp_t y7_o
);

  always_comb begin
    y1_o = round_narrow(mac2(o3_i, K4,  o0_i, K28, 1'b0));
    y5_o = round_narrow(mac2(o1_i, K12, o2_i, K20, 1'b0));
    y3_o = round_narrow(mac2(o2_i, K12, o1_i, K20, 1'b1));
    y7_o = round_narrow(mac2(o3_i, K28, o0_i, K4,  1'b1));
  end

endmodule

// File: rtl/fdct8_pipe.sv
module fdct8_pipe
  import fdct8_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [VEC_W-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VEC_W-1:0] out_data
);

  logic advance;
  logic v1_q, v2_q, v3_q;

  vec_t x_w, s_w, s_q;
  smp_t ev0_w, ev2_w, ev4_w, ev6_w;
  smp_t od0_w, od1_w, od2_w, od3_w;
  smp_t ev0_q, ev2_q, ev4_q, ev6_q;
  smp_t od0_q, od1_q, od2_q, od3_q;
  smp_t y1_w, y3_w, y5_w, y7_w;
  vec_t y_w, y_q;

  assign advance  = !v3_q || out_ready;
  assign in_ready = advance;
  assign x_w      = in_data;

  fdct8_split u_split (
    .x_i (x_w),
    .s_o (s_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
      v3_q <= 1'b0;
    end else if (advance) begin
      v1_q <= in_valid;
      v2_q <= v1_q;
      v3_q <= v2_q;
    end
  end

  always_ff @(posedge clk) begin
    if (advance && in_valid) s_q <= s_w;
  end

  fdct8_even u_even (
    .s0_i (smp_t'(s_q[0])),
    .s1_i (smp_t'(s_q[1])),
    .s2_i (smp_t'(s_q[2])),
    .s3_i (smp_t'(s_q[3])),
    .y0_o (ev0_w),
    .y2_o (ev2_w),
    .y4_o (ev4_w),
    .y6_o (ev6_w)
  );

  fdct8_odd_pre u_odd_pre (
    .s4_i (smp_t'(s_q[4])),
    .s5_i (smp_t'(s_q[5])),
    .s6_i (smp_t'(s_q[6])),
    .s7_i (smp_t'(s_q[7])),
    .o0_o (od0_w),
    .o1_o (od1_w),
    .o2_o (od2_w),
    .o3_o (od3_w)
  );

  always_ff @(posedge clk) begin
    if (advance && v1_q) begin
      ev0_q <= ev0_w;
      ev2_q <= ev2_w;
      ev4_q <= ev4_w;
      ev6_q <= ev6_w;
      od0_q <= od0_w;
      od1_q <= od1_w;
      od2_q <= od2_w;
      od3_q <= od3_w;
    end
  end

  fdct8_odd_post u_odd_post (
    .o0_i (od0_q),
    .o1_i (od1_q),
    .o2_i (od2_q),
    .o3_i (od3_q),
    .y1_o (y1_w),
    .y3_o (y3_w),
    .y5_o (y5_w),
    .y7_o (y7_w)
  );

  assign y_w[0] = ev0_q;
  assign y_w[1] = y1_w;
  assign y_w[2] = ev2_q;
  assign y_w[3] = y3_w;
  assign y_w[4] = ev4_q;
  assign y_w[5] = y5_w;
  assign y_w[6] = ev6_q;
  assign y_w[7] = y7_w;

  always_ff @(posedge clk) begin
    if (advance && v2_q) y_q <= y_w;
  end

  assign out_valid = v3_q;
  assign out_data  = y_q;

  // cycles since reset, saturating; keeps $past inside the post-reset window
  logic [1:0] warm_q;
  logic       accept;
  assign accept = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              warm_q <= 2'd0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R3

  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R11

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd3 && $past(accept, 3) && $past(in_ready, 2) && $past(in_ready, 1))
      |-> out_valid); // R2

  AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R1

endmodule

// File: tb/fdct8_pipe_tb_top.sv
module fdct8_pipe_tb_top;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_data = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [127:0] out_data;

  int    n_checks = 0;
  int    n_errors = 0;
  bit    done = 1'b0;

  logic [127:0] exp_mem [256];
  string        tag_mem [256];
  int           wr = 0;
  int           rd = 0;
  string        cur_tag = "idle";
  bit           prev_stall = 1'b0;
  logic [127:0] prev_data = '0;

  always #5 clk = ~clk;

  fdct8_pipe dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );

  function automatic int w16(int v);
    shortint t;
    t = shortint'(v);
    return int'(t);
  endfunction

  function automatic int rnd(int v);
    return w16((v + 8192) >>> 14);
  endfunction

  function automatic logic [127:0] ref_dct(logic [127:0] xin);
    int x [8];
    int s [8];
    int y [8];
    int e0, e1, e2, e3, p, q, o0, o1, o2, o3;
    logic [127:0] r;
    for (int i = 0; i < 8; i++) x[i] = int'($signed(xin[16*i +: 16]));
    for (int i = 0; i < 4; i++) begin
      s[i]     = w16(x[i] + x[7-i]);
      s[7-i]   = w16(x[i] - x[7-i]);
    end
    e0 = w16(s[0] + s[3]);
    e1 = w16(s[1] + s[2]);
    e2 = w16(s[1] - s[2]);
    e3 = w16(s[0] - s[3]);
    y[0] = rnd((e0 + e1) * 11585);
    y[4] = rnd((e0 - e1) * 11585);
    y[2] = rnd(e2 * 6270 + e3 * 15137);
    y[6] = rnd(e3 * 6270 - e2 * 15137);
    p  = rnd(w16(s[6] - s[5]) * 11585);
    q  = rnd(w16(s[6] + s[5]) * 11585);
    o0 = w16(s[4] + p);
    o1 = w16(s[4] - p);
    o2 = w16(s[7] - q);
    o3 = w16(s[7] + q);
    y[1] = rnd(o3 * 16069 + o0 * 3196);
    y[5] = rnd(o1 * 13623 + o2 * 9102);
    y[3] = rnd(o2 * 13623 - o1 * 9102);
    y[7] = rnd(o3 * 3196 - o0 * 16069);
    for (int k = 0; k < 8; k++) r[16*k +: 16] = y[k][15:0];
    return r;
  endfunction

  function automatic string coef_req(int k);
    if (k == 0 || k == 4) return "R5";
    if (k == 2 || k == 6) return "R6";
    return "R8";
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // called at a falling edge after inputs are driven; ends at the next falling edge
  task automatic step();
    #1;
    if (prev_stall) begin
      check(out_valid === 1'b1, "R3", "out_valid held under stall", longint'(out_valid), 1);
      check(out_data === prev_data, "R3", "out_data stable under stall (low word)",
            longint'(out_data[63:0]), longint'(prev_data[63:0]));
    end
    check(in_ready === !(out_valid && !out_ready), "R3", "in_ready rule",
          longint'(in_ready), longint'(!(out_valid && !out_ready)));
    prev_stall = out_valid && !out_ready;
    prev_data  = out_data;
    if (out_valid && out_ready) begin
      if (rd == wr) begin
        check(1'b0, "R11", "output without pending vector", rd, wr);
      end else begin
        for (int k = 0; k < 8; k++) begin
          check(out_data[16*k +: 16] === exp_mem[rd % 256][16*k +: 16], coef_req(k),
                $sformatf("coef%0d vec[%s]", k, tag_mem[rd % 256]),
                longint'($signed(out_data[16*k +: 16])),
                longint'($signed(exp_mem[rd % 256][16*k +: 16])));
        end
        rd++;
      end
    end
    if (in_valid && in_ready) begin
      exp_mem[wr % 256] = ref_dct(in_data);
      tag_mem[wr % 256] = cur_tag;
      wr++;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send(logic [127:0] v, string tag);
    cur_tag   = tag;
    in_valid  = 1'b1;
    in_data   = v;
    out_ready = 1'b1;
    step();
    in_valid  = 1'b0;
  endtask

  function automatic logic [127:0] fill(int a);
    logic [127:0] r;
    for (int i = 0; i < 8; i++) r[16*i +: 16] = a[15:0];
    return r;
  endfunction

  function automatic logic [15:0] pick_sample();
    int sel;
    sel = int'($urandom % 8);
    if (sel == 0) return 16'h7FFF;
    if (sel == 1) return 16'h8000;
    if (sel == 2) return 16'($urandom % 5) - 16'd2;
    return 16'($urandom);
  endfunction

  initial begin
    logic [127:0] v;
    int lat;
    void'($urandom(32'h0000_5EED));

    // reset state, R1
    repeat (3) @(negedge clk);
    #1;
    check(out_valid === 1'b0, "R1", "out_valid in reset", longint'(out_valid), 0);
    check(in_ready === 1'b1, "R1", "in_ready in reset", longint'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(out_valid === 1'b0, "R1", "out_valid after reset", longint'(out_valid), 0);
    check(in_ready === 1'b1, "R1", "in_ready after reset", longint'(in_ready), 1);
    @(negedge clk);

    // latency, R2
    send(fill(100), "R2 latency");
    lat = 1;
    while (!out_valid && lat < 10) begin
      step();
      lat++;
    end
    check(lat == 3, "R2", "edges from accept to out_valid", lat, 3);
    out_ready = 1'b1;
    repeat (4) step();

    // directed corner cases
    send('0, "R10 zero");
    for (int i = 0; i < 8; i++) begin
      v = '0;
      v[16*i +: 16] = 16'd1000;
      send(v, $sformatf("R10 impulse%0d", i));
    end
    v = '0;
    v[15:0] = 16'h7FFF;
    v[127:112] = 16'h7FFF;
    send(v, "R4 wrap pair07");
    send(fill(32'h7FFF), "R4 all max");
    send(fill(32'h8000), "R4 all min");
    v = '0;
    v[15:0] = 16'd1;
    send(v, "R9 half step");
    v = '0;
    v[15:0] = 16'hFFFF;
    send(v, "R9 negative half step");
    v = '0;
    v[31:16] = 16'd3;
    v[47:32] = 16'hFFFE;
    v[95:80] = 16'd2;
    send(v, "R7 odd intermediate");
    out_ready = 1'b1;
    repeat (5) step();

    // random traffic with back-pressure
    for (int c = 0; c < 600; c++) begin
      cur_tag  = "random";
      in_valid = ($urandom % 10) < 7;
      for (int i = 0; i < 8; i++) in_data[16*i +: 16] = pick_sample();
      out_ready = ($urandom % 10) < 6;
      step();
    end

    // drain and count, R11
    in_valid  = 1'b0;
    out_ready = 1'b1;
    repeat (8) step();
    check(rd == wr, "R11", "results vs accepted vectors", rd, wr);
    check(wr > 300, "R11", "enough vectors accepted", wr, 301);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL R11 watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule